// File: doc/BRIEF.md
# Randomized Transmit Backoff Scheduler

This block decides how long a transmitter waits before each attempt to send a packet, and tells it when to start. It keeps a retransmission mask for the current packet. Each accepted attempt request widens the mask by one bit. The first attempt of a packet always waits a fixed gap of about 1 ms, which lets half-duplex receivers recover after the previous packet. Later attempts wait a pseudo-random number of slot times. That number comes from the low bits of a free-running clock, mixed with a channel number and limited by the mask.

The wait is counted in base-tick strobes. Eight base ticks make one slot, and a slot is 512 bit times on a 10 Mb/s wire. The base-tick count is split in two parts: a short 6-bit chunk timer, and a count of the remaining 64-tick chunks. When the wait ends, the block raises a one-cycle go strobe. A computed wait of zero raises go at once. If the mask would reach its top bit, the attempt is abandoned and an overflow error strobe is raised instead. Loading a new packet descriptor clears the mask.

Top module: `backoff_sched`

## Requirements
- R1: Reset clears the mask to 0. A load_i pulse also clears the mask to 0. load_i takes priority over a start_i in the same cycle, and that start is dropped (no go_o, no ovf_o).
- R2: A start_i accepted while idle replaces the mask M with (M << 1) | 1. The new value is visible the cycle after the start.
- R3: If the new mask would have its top bit (bit 15) set, the attempt is abandoned. ovf_o pulses for one cycle, in the cycle after the start. The mask keeps its old value and go_o stays low.
- R4: When the new mask equals 1 (first attempt), the delay is 20 slots, which is 160 base ticks.
- R5: On later attempts the delay, in slots, is (rand_i[9:0] XOR chan_i zero-extended) AND old_mask[9:0].
- R6: One slot is 8 base ticks. go_o rises after the D*8-th tick_i pulse that is sampled after the accepting edge. The wait is counted in ticks, not clock cycles.
- R7: A delay of zero raises go_o in the cycle right after the start, without arming the timer.
- R8: go_o is high for exactly one cycle.
- R9: A start_i that arrives while a wait is running is ignored. The mask is unchanged and go_o comes at its original time.
- R10: tick_i pulses while no wait is armed have no effect. go_o stays low.
- R11: Delays longer than one 64-tick chunk are exact. This includes delays whose low 6 tick bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | New packet descriptor loaded; clears mask |
| start_i | input | 1 | Request a transmit attempt |
| rand_i | input | 10 | Low bits of a free-running clock |
| chan_i | input | 4 | Channel number mixed into the random value |
| tick_i | input | 1 | Base-tick strobe (one eighth of a slot) |
| go_o | output | 1 | One-cycle strobe: start transmitting |
| ovf_o | output | 1 | One-cycle strobe: attempt count exhausted |
| mask_o | output | 16 | Current retransmission mask |

## Verification
The bench walks one packet through all sixteen attempts, so the mask passes through every width from 0 up to overflow. For each attempt the expected wait is computed from the mask model, the random bits and the channel. The first attempt shows the fixed gap. One attempt is built so that its random value masks to zero, which separates immediate go from a timed wait. One attempt runs with sparse ticks, which shows that the count is in ticks and not in cycles. A crafted 16-slot delay has a zero low part and so exercises the chunk reload path. One attempt receives an extra start mid-wait, and idle periods with ticks running show that idle ticks and in-wait starts change nothing.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
   typedef enum logic [0:0] {
      BK_IDLE = 1'b0,
      BK_WAIT = 1'b1
   } bk_state_e;
endpackage

// File: rtl/backoff_mask.sv
module backoff_mask #(
   parameter int MASK_W      = 16,
   parameter int RAND_W      = 10,
   parameter int CHAN_W      = 4,
   parameter int FIRST_SLOTS = 20,
   parameter bit USE_CHAN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              step_i,
   input  logic [RAND_W-1:0] rand_i,
   input  logic [CHAN_W-1:0] chan_i,
   output logic [MASK_W-1:0] mask_o,
   output logic              ovf_o,
   output logic [RAND_W-1:0] delay_o
);
   logic [MASK_W-1:0] mask_q;
   logic [MASK_W-1:0] grown;
   logic [RAND_W-1:0] seed;

   // the channel mix is optional
   generate
      if (USE_CHAN) begin : g_mix
         assign seed = rand_i ^ {{(RAND_W-CHAN_W){1'b0}}, chan_i};
      end else begin : g_plain
         assign seed = rand_i;
      end
   endgenerate

   assign grown   = {mask_q[MASK_W-2:0], 1'b1};
   assign ovf_o   = grown[MASK_W-1];
   assign delay_o = (mask_q == '0) ? RAND_W'(FIRST_SLOTS)
                                   : (seed & mask_q[RAND_W-1:0]);
   assign mask_o  = mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mask_q <= '0;
      else if (clear_i)           mask_q <= '0;
      else if (step_i && !ovf_o)  mask_q <= grown;
   end
endmodule

// File: rtl/backoff_timer.sv
module backoff_timer #(
   parameter int TMR_W = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           arm_i,
   input  logic [TMR_W:0] load_i,
   input  logic           tick_i,
   output logic           expire_o
);
   logic [TMR_W:0] cnt_q;
   logic           armed_q;

   assign expire_o = armed_q && tick_i && (cnt_q == (TMR_W+1)'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (arm_i) begin
         cnt_q   <= load_i;
         armed_q <= 1'b1;
      end else if (expire_o) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (armed_q && tick_i) begin
         cnt_q   <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/backoff_sched.sv
module backoff_sched #(
   parameter int MASK_W      = 16,
   parameter int RAND_W      = 10,
   parameter int CHAN_W      = 4,
   parameter int SLOT_LG     = 3,
   parameter int TMR_W       = 6,
   parameter int FIRST_SLOTS = 20,
   parameter bit USE_CHAN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              start_i,
   input  logic [RAND_W-1:0] rand_i,
   input  logic [CHAN_W-1:0] chan_i,
   input  logic              tick_i,
   output logic              go_o,
   output logic              ovf_o,
   output logic [MASK_W-1:0] mask_o
);
   import backoff_pkg::*;

   localparam int BASE_W = RAND_W + SLOT_LG;
   localparam int HI_W   = BASE_W - TMR_W;
   localparam logic [TMR_W:0] CHUNK_V = (TMR_W+1)'(1 << TMR_W);

   generate
      if (MASK_W <= RAND_W)          begin : g_bad_mask  $error("MASK_W must exceed RAND_W"); end
      if (CHAN_W >= RAND_W)          begin : g_bad_chan  $error("CHAN_W must be below RAND_W"); end
      if (TMR_W <= SLOT_LG)          begin : g_bad_tmr   $error("TMR_W must exceed SLOT_LG"); end
      if (FIRST_SLOTS >= (1 << RAND_W)) begin : g_bad_first $error("FIRST_SLOTS too large"); end
   endgenerate

   bk_state_e         state_q;
   logic [HI_W-1:0]   hi_q;
   logic              accept, step_ovf, expire, timer_arm, fin;
   logic [RAND_W-1:0] delay;
   logic [BASE_W-1:0] base;
   logic [TMR_W-1:0]  lo_part;
   logic [HI_W-1:0]   hi_part;
   logic [TMR_W:0]    arm_val;
   logic              expire_raw;

   assign accept = start_i && !load_i && (state_q == BK_IDLE);

   backoff_mask #(
      .MASK_W(MASK_W), .RAND_W(RAND_W), .CHAN_W(CHAN_W),
      .FIRST_SLOTS(FIRST_SLOTS), .USE_CHAN(USE_CHAN)
   ) u_mask (
      .clk(clk), .rst_n(rst_n), .clear_i(load_i), .step_i(accept),
      .rand_i(rand_i), .chan_i(chan_i),
      .mask_o(mask_o), .ovf_o(step_ovf), .delay_o(delay)
   );

   // delay in base ticks, split into chunk-timer part and chunk count
   assign base    = {delay, {SLOT_LG{1'b0}}};
   assign lo_part = base[TMR_W-1:0];
   assign hi_part = base[BASE_W-1:TMR_W];

   // an expiry outside a wait is spurious and dropped
   assign expire = expire_raw && (state_q == BK_WAIT);
   assign fin    = expire && (hi_q == '0);

   always_comb begin
      timer_arm = 1'b0;
      arm_val   = CHUNK_V;
      if (accept && !step_ovf && (delay != '0)) begin
         timer_arm = 1'b1;
         arm_val   = (lo_part != '0) ? {1'b0, lo_part} : CHUNK_V;
      end else if (expire && (hi_q != '0)) begin
         timer_arm = 1'b1;
      end
   end

   backoff_timer #(.TMR_W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .arm_i(timer_arm), .load_i(arm_val),
      .tick_i(tick_i), .expire_o(expire_raw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BK_IDLE;
         hi_q    <= '0;
         go_o    <= 1'b0;
         ovf_o   <= 1'b0;
      end else begin
         go_o  <= (accept && !step_ovf && (delay == '0)) || fin;
         ovf_o <= accept && step_ovf;
         if (accept && !step_ovf && (delay != '0)) begin
            state_q <= BK_WAIT;
            hi_q    <= (lo_part != '0) ? hi_part : hi_part - 1'b1;
         end else if (fin) begin
            state_q <= BK_IDLE;
         end else if (expire) begin
            hi_q    <= hi_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/backoff_sched_chk.sv
module backoff_sched_chk #(
   parameter int MASK_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic              start_i,
   input logic              go_o,
   input logic              ovf_o,
   input logic [MASK_W-1:0] mask_o,
   input logic              waiting
);
   assert_load_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (mask_o == '0));

   assert_mask_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !load_i && !waiting && !mask_o[MASK_W-2])
      |=> (mask_o == {$past(mask_o[MASK_W-2:0]), 1'b1}));

   assert_no_top_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_o[MASK_W-1]);

   assert_ovf_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> !ovf_o);

   assert_ovf_not_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_o && go_o));

   assert_go_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      go_o |=> !go_o);

   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && waiting && !load_i) |=> $stable(mask_o));
endmodule

bind backoff_sched backoff_sched_chk #(.MASK_W(MASK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
   .go_o(go_o), .ovf_o(ovf_o), .mask_o(mask_o),
   .waiting(state_q == backoff_pkg::BK_WAIT)
);

// File: tb/backoff_sched_bench.sv
module backoff_sched_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic        start_i = 1'b0;
   logic [9:0]  rand_i = '0;
   logic [3:0]  chan_i = '0;
   logic        tick_i = 1'b1;
   logic        go_o, ovf_o;
   logic [15:0] mask_o;

   int checks = 0;
   int errors = 0;
   logic [15:0] model_m;

   always #2.5 clk = ~clk;

   backoff_sched u_backoff_sched (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
      .rand_i(rand_i), .chan_i(chan_i), .tick_i(tick_i),
      .go_o(go_o), .ovf_o(ovf_o), .mask_o(mask_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one attempt: expected wait in base ticks, tick period in cycles,
   // cycle index of an extra start during the wait (-1 for none)
   task automatic attempt(input logic [9:0] src, input logic [3:0] ch,
                          input int every, input int inject, input string req);
      int exp_slots, exp_ticks, ticks, got;
      logic [15:0] new_m;
      new_m     = {model_m[14:0], 1'b1};
      exp_slots = (model_m == 16'h0) ? 20 : int'((src ^ {6'b0, ch}) & model_m[9:0]);
      exp_ticks = exp_slots * 8;
      @(negedge clk);
      rand_i = src; chan_i = ch; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk(mask_o == new_m, "R2 mask growth", int'(mask_o), int'(new_m));
      model_m = new_m;
      ticks = 0; got = -1;
      for (int cyc = 0; cyc < 20000 && got < 0; cyc++) begin
         if (go_o) got = ticks;
         else begin
            logic t;
            tick_i  = ((cyc % every) == 0);
            start_i = (cyc == inject);
            if (cyc == inject) rand_i = ~src;
            t = tick_i;
            @(posedge clk);
            if (t) ticks++;
            @(negedge clk);
            start_i = 1'b0;
         end
      end
      tick_i = 1'b1;
      chk(got == exp_ticks, req, got, exp_ticks);
      @(negedge clk);
      chk(go_o == 1'b0, "R8 go single cycle", int'(go_o), 0);
      if (inject >= 0)
         chk(mask_o == model_m, "R9 mask after ignored start", int'(mask_o), int'(model_m));
   endtask

   initial begin
      #(190000 * 5);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int idle_go;
      repeat (3) @(negedge clk);
      chk(mask_o == 16'h0, "R1 reset mask", int'(mask_o), 0);
      chk(go_o == 1'b0 && ovf_o == 1'b0, "R1 reset strobes", int'({go_o, ovf_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: ticks while idle do nothing
      idle_go = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (go_o) idle_go++;
      end
      chk(idle_go == 0, "R10 idle ticks", idle_go, 0);

      model_m = 16'h0;
      attempt(10'h000, 4'h0, 1, -1, "R4 first-attempt gap");
      attempt(10'h001, 4'h5, 1, -1, "R7 zero delay immediate");
      for (int k = 3; k <= 15; k++) begin
         logic [15:0] s;
         s = 16'h5A5A + 16'(k) * 16'h1357;
         if (k == 5)      attempt(s[9:0], 4'(k), 3, -1, "R6 sparse ticks");
         else if (k == 7) attempt(s[9:0], 4'(k), 1, 40, "R9 start during wait");
         else             attempt(s[9:0], 4'(k), 1, -1, "R5 random delay");
      end

      // R3: sixteenth attempt overflows
      @(negedge clk);
      rand_i = 10'h3FF; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk(ovf_o == 1'b1, "R3 overflow strobe", int'(ovf_o), 1);
      chk(go_o == 1'b0, "R3 no go on overflow", int'(go_o), 0);
      chk(mask_o == 16'h7FFF, "R3 mask held", int'(mask_o), 32767);
      @(negedge clk);
      chk(ovf_o == 1'b0, "R3 overflow single cycle", int'(ovf_o), 0);
      idle_go = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (go_o) idle_go++;
      end
      chk(idle_go == 0, "R10 no go after abandon", idle_go, 0);

      // R1: load with simultaneous start
      @(negedge clk);
      load_i = 1'b1; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      load_i = 1'b0; start_i = 1'b0;
      chk(mask_o == 16'h0, "R1 load clears mask", int'(mask_o), 0);
      chk(go_o == 1'b0 && ovf_o == 1'b0, "R1 start dropped on load", int'({go_o, ovf_o}), 0);

      // R11: chunk split; build mask 0x1F, then a 16-slot delay (128 ticks)
      model_m = 16'h0;
      attempt(10'h000, 4'h0, 1, -1, "R4 first gap after load");
      for (int k = 2; k <= 5; k++) attempt(10'h000, 4'h0, 1, -1, "R7 zero delay");
      attempt(10'h013, 4'h3, 1, -1, "R11 two full chunks");
      attempt(10'h049, 4'h0, 1, -1, "R11 chunk plus remainder");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule